// File: doc/BRIEF.md
# Paravirtual Device Legacy Register File

This block is the slave register file of a legacy paravirtual I/O device. It sits on a simple register bus that carries byte, halfword and word accesses. It holds the feature words offered by the host and accepted by the guest, a queue selector, and the per-queue page-frame numbers and interrupt vectors. It also presents a fixed size for each queue, a device status byte and an interrupt status byte that clears when it is read. It drives a legacy level interrupt.

A write to the notify register raises a one-cycle pulse that carries the queue index, so a queue engine elsewhere can pick up the work. The common registers occupy a small window at the bottom of the address range. Any access at or above that window is passed through to a device-specific configuration port, with the address rebased to zero.

The window is 20 bytes when message-signalled vectors are disabled and 24 bytes when they are enabled. Two operations reset the whole device in a single cycle: writing zero to the status byte, and writing zero to a queue frame number.

Top module: `pvdev_regfile`

## Requirements
- R1: Every bus read returns its data on `bus_rdata` with `bus_rvalid` high exactly one cycle after the request. The host-feature word (parameter `HOST_FEAT`) reads at offset 0, and a write to offset 0 does not change it.
- R2: The guest-feature word at offset 4 stores a written value and reads it back. If bit 30 (the bad-feature flag) of the written value is set, the stored value is `HOST_FEAT & FALLBACK_MASK` when `HAS_FALLBACK` is 1, and 0 otherwise.
- R3: A write to the queue selector at offset 14 with a value below `NQ` (16) is stored and reads back. A value of `NQ` or more is ignored and the previous selection remains.
- R4: The frame number at offset 8 is stored for the selected queue only and reads back for that queue. The read-only size at offset 12 is `QSIZE_UNIT*(q+1)` for selected queue q.
- R5: Writing zero to the frame number, or zero in bits 7:0 to the status byte at offset 18, resets the device in one cycle. After the reset the guest features, status, ISR and every queue frame number read 0, and the configuration vector and every queue vector read 0xFFFF.
- R6: A status write stores bits 7:0 of the written data.
- R7: Reading the ISR at offset 19 returns its contents and clears it. Bits of the `isr_set` input are ORed into the ISR. If a set and a read-clear happen in the same cycle, the set wins: the read returns the old value and the new bits remain.
- R8: With `vec_en` low, `irq_level` equals ISR bit 0 in the same cycle that the ISR changes. With `vec_en` high, `irq_level` stays low.
- R9: A write to offset 16 with a value below `NQ` produces a one-cycle `notify_valid` pulse, with `notify_queue` equal to the value, in the cycle after the write. A value of `NQ` or more produces no pulse.
- R10: With `vec_en` high, the configuration vector is at offset 20 and the selected queue's vector is at offset 22. A written value of `NUM_VEC` or more (allocation failure) reads back 0xFFFF. Both vectors read 0xFFFF after reset.
- R11: The common window is 20 bytes when `vec_en` is low and 24 bytes when it is high. An access at or above the window drives `cfg_valid` with `cfg_addr` equal to the offset minus the window, and a read returns `cfg_rdata`.
- R12: Reads of unmapped offsets inside the window, and reads of the notify offset, return 0xFFFFFFFF. Writes to unmapped or read-only offsets change no register.
- R13: A falling edge on `bus_master_en` clears status bit 2 (driver ready) and leaves the other status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset into the device window |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| vec_en | input | 1 | Message-signalled vectors enabled |
| bus_master_en | input | 1 | Bus-master enable from the command register |
| isr_set | input | 8 | Device-side interrupt events, ORed into the ISR |
| irq_level | output | 1 | Legacy level interrupt |
| notify_valid | output | 1 | Queue notify pulse |
| notify_queue | output | QW | Queue index of the notify |
| cfg_valid | output | 1 | Forwarded device-config access |
| cfg_write | output | 1 | Forwarded access is a write |
| cfg_addr | output | AW | Rebased device-config offset |
| cfg_size | output | 2 | Forwarded access width |
| cfg_wdata | output | 32 | Forwarded write data |
| cfg_rdata | input | 32 | Device-config read data |

## Verification
The hardest case to reach is an interrupt event that arrives in the same clock cycle as the ISR read that clears it. The stimulus reaches it by driving `isr_set` inside the same bus read task, on the same edge as the read request. The bench then re-reads the ISR to confirm that the new bit survived while the returned value was the old one.

The one-cycle device reset is also hard to observe, because its effect is spread across many queues. The bench first fills every queue slot, vector and the ISR with distinct values. It then triggers the reset and sweeps all queues through the selector.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;
  localparam int OFF_HOSTF  = 0;
  localparam int OFF_GUESTF = 4;
  localparam int OFF_PFN    = 8;
  localparam int OFF_QSIZE  = 12;
  localparam int OFF_QSEL   = 14;
  localparam int OFF_NOTIFY = 16;
  localparam int OFF_STATUS = 18;
  localparam int OFF_ISR    = 19;
  localparam int OFF_CFGVEC = 20;
  localparam int OFF_QVEC   = 22;
  localparam int WIN_PLAIN  = 20;
  localparam int WIN_VEC    = 24;
  localparam logic [15:0] NOVEC = 16'hFFFF;
  localparam int DRV_OK_BIT = 2;

  typedef enum logic [3:0] {
    RS_NONE, RS_HOSTF, RS_GUESTF, RS_PFN, RS_QSIZE, RS_QSEL,
    RS_NOTIFY, RS_STATUS, RS_ISR, RS_CFGVEC, RS_QVEC
  } regsel_e;
endpackage

// File: rtl/pvdev_decode.sv
module pvdev_decode
  import pvdev_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          vec_en,
  output regsel_e       sel,
  output logic          fwd,
  output logic [AW-1:0] fwd_addr
);
  logic [AW-1:0] win;

  always_comb begin
    win = vec_en ? AW'(WIN_VEC) : AW'(WIN_PLAIN);
    fwd = (addr >= win);
    fwd_addr = addr - win;
    sel = RS_NONE;
    if (!fwd) begin
      case (addr)
        AW'(OFF_HOSTF):  sel = RS_HOSTF;
        AW'(OFF_GUESTF): sel = RS_GUESTF;
        AW'(OFF_PFN):    sel = RS_PFN;
        AW'(OFF_QSIZE):  sel = RS_QSIZE;
        AW'(OFF_QSEL):   sel = RS_QSEL;
        AW'(OFF_NOTIFY): sel = RS_NOTIFY;
        AW'(OFF_STATUS): sel = RS_STATUS;
        AW'(OFF_ISR):    sel = RS_ISR;
        AW'(OFF_CFGVEC): sel = RS_CFGVEC;
        AW'(OFF_QVEC):   sel = RS_QVEC;
        default:         sel = RS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pvdev_isr.sv
module pvdev_isr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         rd_clr,
  input  logic         wipe,
  output logic [W-1:0] isr,
  output logic [W-1:0] isr_nxt
);
  always_comb isr_nxt = ((rd_clr || wipe) ? '0 : isr) | set;

  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= isr_nxt;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((isr & $past(set)) == $past(set))); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !(|set)) |=> (isr == '0)); // R7
endmodule

// File: rtl/pvdev_qtable.sv
module pvdev_qtable #(
  parameter int NQ = 16,
  parameter int QW = 4,
  parameter int PW = 32,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wipe,
  input  logic [QW-1:0] sel,
  input  logic          pfn_we,
  input  logic [PW-1:0] pfn_wdata,
  input  logic          vec_we,
  input  logic [VW-1:0] vec_wdata,
  output logic [PW-1:0] pfn_rd,
  output logic [VW-1:0] vec_rd
);
  logic [PW-1:0] pfn_mem [NQ];
  logic [VW-1:0] vec_mem [NQ];
  logic [NQ-1:0] pfn_ok;
  logic [NQ-1:0] vec_ok;

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (pfn_we) pfn_mem[sel] <= pfn_wdata;
    if (vec_we) vec_mem[sel] <= vec_wdata;
  end

  // one-cycle wipe through per-entry valid flags
  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      pfn_ok <= '0;
      vec_ok <= '0;
    end else begin
      if (pfn_we) pfn_ok[sel] <= 1'b1;
      if (vec_we) vec_ok[sel] <= 1'b1;
    end
  end

  always_comb begin
    pfn_rd = pfn_ok[sel] ? pfn_mem[sel] : '0;
    vec_rd = vec_ok[sel] ? vec_mem[sel] : '1;
  end

  AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (pfn_rd == '0 && vec_rd == '1)); // R5
endmodule

// File: rtl/pvdev_regfile.sv
module pvdev_regfile
  import pvdev_pkg::*;
#(
  parameter int          AW            = 8,
  parameter int          NQ            = 16,
  parameter int          NUM_VEC       = 8,
  parameter int          QSIZE_UNIT    = 64,
  parameter logic [31:0] HOST_FEAT     = 32'h4100_0023,
  parameter logic [31:0] FALLBACK_MASK = 32'h0000_0021,
  parameter bit          HAS_FALLBACK  = 1'b1,
  parameter int          BAD_FEAT_BIT  = 30,
  localparam int         QW            = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_rvalid,
  input  logic          vec_en,
  input  logic          bus_master_en,
  input  logic [7:0]    isr_set,
  output logic          irq_level,
  output logic          notify_valid,
  output logic [QW-1:0] notify_queue,
  output logic          cfg_valid,
  output logic          cfg_write,
  output logic [AW-1:0] cfg_addr,
  output logic [1:0]    cfg_size,
  output logic [31:0]   cfg_wdata,
  input  logic [31:0]   cfg_rdata
);
  localparam logic [31:0] BAD_VALUE = HAS_FALLBACK ? (HOST_FEAT & FALLBACK_MASK) : 32'h0;

  regsel_e       sel;
  logic          fwd;
  logic [AW-1:0] fwd_addr;
  logic          wr, rd, wipe, bm_q, bm_fall;
  logic [31:0]   guest_f;
  logic [7:0]    status, st_n;
  logic [QW-1:0] qsel;
  logic [15:0]   cfg_vec, vec_map, qsize_cur;
  logic [31:0]   pfn_rd, rd_mux;
  logic [15:0]   qvec_rd;
  logic [7:0]    isr, isr_nxt;
  logic          wr_lo_in_range;

  pvdev_decode #(.AW(AW)) u_decode (
    .addr(bus_addr), .vec_en(vec_en), .sel(sel), .fwd(fwd), .fwd_addr(fwd_addr)
  );

  always_comb begin
    wr   = bus_valid && bus_write && !fwd;
    rd   = bus_valid && !bus_write && !fwd;
    wipe = wr && ((sel == RS_PFN && bus_wdata == 32'h0) ||
                  (sel == RS_STATUS && bus_wdata[7:0] == 8'h0));
    bm_fall = bm_q && !bus_master_en;
    wr_lo_in_range = (bus_wdata[15:0] < 16'(NQ));
    vec_map = (bus_wdata[15:0] < 16'(NUM_VEC)) ? bus_wdata[15:0] : NOVEC;
    qsize_cur = 16'(QSIZE_UNIT * (int'(qsel) + 1));
  end

  pvdev_isr #(.W(8)) u_isr (
    .clk(clk), .rst(rst), .set(isr_set), .rd_clr(rd && sel == RS_ISR),
    .wipe(wipe), .isr(isr), .isr_nxt(isr_nxt)
  );

  pvdev_qtable #(.NQ(NQ), .QW(QW), .PW(32), .VW(16)) u_qtable (
    .clk(clk), .rst(rst), .wipe(wipe), .sel(qsel),
    .pfn_we(wr && sel == RS_PFN && bus_wdata != 32'h0), .pfn_wdata(bus_wdata),
    .vec_we(wr && sel == RS_QVEC), .vec_wdata(vec_map),
    .pfn_rd(pfn_rd), .vec_rd(qvec_rd)
  );

  always_comb begin
    st_n = status;
    if (wipe) st_n = 8'h0;
    else if (wr && sel == RS_STATUS) st_n = bus_wdata[7:0];
    if (bm_fall) st_n[DRV_OK_BIT] = 1'b0;
  end

  always_comb begin
    case (sel)
      RS_HOSTF:  rd_mux = HOST_FEAT;
      RS_GUESTF: rd_mux = guest_f;
      RS_PFN:    rd_mux = pfn_rd;
      RS_QSIZE:  rd_mux = {16'h0, qsize_cur};
      RS_QSEL:   rd_mux = 32'(qsel);
      RS_STATUS: rd_mux = {24'h0, status};
      RS_ISR:    rd_mux = {24'h0, isr};
      RS_CFGVEC: rd_mux = {16'h0, cfg_vec};
      RS_QVEC:   rd_mux = {16'h0, qvec_rd};
      default:   rd_mux = 32'hFFFF_FFFF;
    endcase
    if (fwd) rd_mux = cfg_rdata;
  end

  always_ff @(posedge clk) bm_q <= bus_master_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      guest_f      <= 32'h0;
      status       <= 8'h0;
      qsel         <= '0;
      cfg_vec      <= NOVEC;
      notify_valid <= 1'b0;
      notify_queue <= '0;
      bus_rvalid   <= 1'b0;
      bus_rdata    <= 32'h0;
      irq_level    <= 1'b0;
    end else begin
      status <= st_n;
      if (wipe) guest_f <= 32'h0;
      else if (wr && sel == RS_GUESTF)
        guest_f <= bus_wdata[BAD_FEAT_BIT] ? BAD_VALUE : bus_wdata;
      if (wipe) cfg_vec <= NOVEC;
      else if (wr && sel == RS_CFGVEC) cfg_vec <= vec_map;
      if (wr && sel == RS_QSEL && wr_lo_in_range) qsel <= bus_wdata[QW-1:0];
      notify_valid <= wr && sel == RS_NOTIFY && wr_lo_in_range;
      notify_queue <= bus_wdata[QW-1:0];
      bus_rvalid   <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= rd_mux;
      irq_level    <= !vec_en && isr_nxt[0];
    end
  end

  always_comb begin
    cfg_valid = bus_valid && fwd;
    cfg_write = bus_write;
    cfg_addr  = fwd_addr;
    cfg_size  = bus_size;
    cfg_wdata = bus_wdata;
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid); // R1
  AST_QSEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == RS_QSEL && !wr_lo_in_range) |=> $stable(qsel)); // R3
  AST_STATUS_ZERO_RESETS: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == RS_STATUS && bus_wdata[7:0] == 8'h0) |=> (guest_f == 32'h0 && status == 8'h0)); // R5
  AST_IRQ_TRACKS_ISR: assert property (@(posedge clk) disable iff (rst)
    $past(!vec_en) |-> (irq_level == isr[0])); // R8
  AST_NOTIFY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    notify_valid |-> $past(bus_valid && bus_write)); // R9
  AST_VEC_ALLOC_FAIL: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == RS_CFGVEC && bus_wdata[15:0] >= 16'(NUM_VEC)) |=> (cfg_vec == NOVEC)); // R10
  AST_MASTER_OFF_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_master_en) |=> !status[DRV_OK_BIT]); // R13
endmodule

// File: tb/pvdev_regfile_bench.sv
module pvdev_regfile_bench;
  localparam int AW = 8;
  localparam int NQ = 16;
  localparam int QW = 4;
  localparam logic [31:0] HOST = 32'h4100_0023;
  localparam logic [31:0] FBM  = 32'h0000_0021;

  logic clk = 0, rst = 1;
  logic bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [1:0] bus_size = 2;
  logic [31:0] bus_wdata = 0, bus_rdata, cfg_wdata, cfg_rdata;
  logic bus_rvalid, vec_en = 1, bus_master_en = 1, irq_level, notify_valid;
  logic [7:0] isr_set = 0;
  logic [QW-1:0] notify_queue;
  logic cfg_valid, cfg_write;
  logic [AW-1:0] cfg_addr;
  logic [1:0] cfg_size;

  int checks = 0, errors = 0;
  bit done = 0;
  logic cap_valid;
  logic [AW-1:0] cap_addr;
  logic [31:0] cap_wdata;

  // bench model
  logic [31:0] m_guest = 0;
  logic [31:0] m_pfn [NQ];
  logic [15:0] m_qvec [NQ];
  logic [15:0] m_cvec = 16'hFFFF;
  logic [7:0]  m_status = 0, m_isr = 0;
  int m_qsel = 0;

  always #4 clk = ~clk;
  assign cfg_rdata = 32'hC0DE_0000 | {24'h0, cfg_addr};

  pvdev_regfile u_pvdev_regfile (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .vec_en(vec_en),
    .bus_master_en(bus_master_en), .isr_set(isr_set), .irq_level(irq_level),
    .notify_valid(notify_valid), .notify_queue(notify_queue),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = AW'(off); bus_wdata = d;
    #1;
    cap_valid = cfg_valid; cap_addr = cfg_addr; cap_wdata = cfg_wdata;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input int off, input logic [7:0] set, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = AW'(off); isr_set = set;
    @(negedge clk);
    bus_valid = 0; isr_set = 0;
    check("R1 rvalid", {31'h0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_rd(input int off, input bit ven);
    int win = ven ? 24 : 20;
    if (off >= win) return 32'hC0DE_0000 | 32'(off - win);
    case (off)
      0:  return HOST;
      4:  return m_guest;
      8:  return m_pfn[m_qsel];
      12: return 32'(64 * (m_qsel + 1));
      14: return 32'(m_qsel);
      18: return {24'h0, m_status};
      19: return {24'h0, m_isr};
      20: return {16'h0, m_cvec};
      22: return {16'h0, m_qvec[m_qsel]};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic sweep(input bit ven, input string req);
    logic [31:0] d;
    vec_en = ven;
    for (int off = 0; off < 32; off++) begin
      rd(off, 8'h0, d);
      check(req, d, exp_rd(off, ven));
      if (off == 19) m_isr = 0;
    end
  endtask

  task automatic model_wipe();
    m_guest = 0; m_status = 0; m_isr = 0; m_cvec = 16'hFFFF;
    for (int q = 0; q < NQ; q++) begin m_pfn[q] = 0; m_qvec[q] = 16'hFFFF; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    model_wipe();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    check("R1 reset rvalid", {31'h0, bus_rvalid}, 32'h0);
    check("R9 reset notify", {31'h0, notify_valid}, 32'h0);
    check("R8 reset irq", {31'h0, irq_level}, 32'h0);
    sweep(1'b1, "R10 reset map");

    // R2 guest features
    wr(4, 32'h1234_5678); m_guest = 32'h1234_5678;
    rd(4, 0, d); check("R2 guest plain", d, m_guest);
    wr(4, 32'h4000_0001); m_guest = HOST & FBM;
    rd(4, 0, d); check("R2 bad feature fallback", d, m_guest);
    wr(0, 32'h0); rd(0, 0, d); check("R12 host read only", d, HOST);

    // R3 selector sweep including out-of-range values
    for (int v = 0; v < 20; v++) begin
      int v2 = (v * 7) % 20;
      wr(14, 32'(v2));
      if (v2 < NQ) m_qsel = v2;
      rd(14, 0, d); check("R3 queue select", d, 32'(m_qsel));
    end

    // R4 frame numbers and sizes over every queue, R10 queue vectors
    for (int q = 0; q < NQ; q++) begin
      wr(14, 32'(q)); m_qsel = q;
      wr(8, 32'h0001_0000 | 32'(q * 16'h0111) | 32'h1); m_pfn[q] = 32'h0001_0000 | 32'(q * 16'h0111) | 32'h1;
      wr(22, 32'(q)); m_qvec[q] = (q < 8) ? 16'(q) : 16'hFFFF;
    end
    for (int q = 0; q < NQ; q++) begin
      wr(14, 32'(q)); m_qsel = q;
      rd(8, 0, d);  check("R4 frame number", d, m_pfn[q]);
      rd(12, 0, d); check("R4 queue size", d, 32'(64 * (q + 1)));
      rd(22, 0, d); check("R10 queue vector", d, {16'h0, m_qvec[q]});
    end

    // R10 config vector allocation
    begin
      logic [15:0] vals [6] = '{16'd0, 16'd3, 16'd7, 16'd8, 16'd100, 16'hFFFF};
      foreach (vals[i]) begin
        wr(20, {16'h0, vals[i]}); m_cvec = (vals[i] < 8) ? vals[i] : 16'hFFFF;
        rd(20, 0, d); check("R10 config vector", d, {16'h0, m_cvec});
      end
    end
    wr(20, 32'd5); m_cvec = 16'd5;

    // R6 status low byte, R13 bus master drop
    wr(18, 32'h0000_0107); m_status = 8'h07;
    rd(18, 0, d); check("R6 status byte", d, 32'h07);
    @(negedge clk); bus_master_en = 0;
    @(negedge clk); @(negedge clk); m_status = 8'h03;
    rd(18, 0, d); check("R13 driver ready cleared", d, 32'h03);
    bus_master_en = 1;

    // R7/R8 ISR behaviour without vectors
    vec_en = 0;
    @(negedge clk); isr_set = 8'h01;
    @(negedge clk); isr_set = 8'h00;
    check("R8 irq follows isr", {31'h0, irq_level}, 32'h1);
    rd(19, 0, d); check("R7 isr read value", d, 32'h01);
    check("R8 irq drops on read", {31'h0, irq_level}, 32'h0);
    rd(19, 0, d); check("R7 isr cleared", d, 32'h00);
    @(negedge clk); isr_set = 8'h02;
    @(negedge clk); isr_set = 8'h00;
    rd(19, 8'h04, d); check("R7 read with same-cycle set", d, 32'h02);
    rd(19, 0, d); check("R7 set wins over clear", d, 32'h04);
    vec_en = 1;
    @(negedge clk); isr_set = 8'h01;
    @(negedge clk); isr_set = 8'h00;
    @(negedge clk);
    check("R8 irq low with vectors", {31'h0, irq_level}, 32'h0);
    rd(19, 0, d); check("R7 isr with vectors", d, 32'h01);

    // R9 notify
    wr(16, 32'd5);
    check("R9 notify pulse", {31'h0, notify_valid}, 32'h1);
    check("R9 notify queue", 32'(notify_queue), 32'd5);
    @(negedge clk);
    check("R9 pulse one cycle", {31'h0, notify_valid}, 32'h0);
    wr(16, 32'd16);
    check("R9 out of range no pulse", {31'h0, notify_valid}, 32'h0);

    // R11 forwarding and R12 unmapped writes
    vec_en = 0;
    wr(26, 32'hA5A5_0001);
    check("R11 forward valid", {31'h0, cap_valid}, 32'h1);
    check("R11 forward address", 32'(cap_addr), 32'd6);
    check("R11 forward data", cap_wdata, 32'hA5A5_0001);
    vec_en = 1;
    wr(15, 32'hFFFF); wr(21, 32'h0); wr(12, 32'h0); wr(19, 32'h0);
    sweep(1'b1, "R12 map with vectors");
    sweep(1'b0, "R11 map without vectors");

    // R5 reset through frame number zero
    vec_en = 1;
    @(negedge clk); isr_set = 8'h80;
    @(negedge clk); isr_set = 8'h00;
    wr(18, 32'h0F); wr(4, 32'h11);
    wr(8, 32'h0); model_wipe();
    sweep(1'b1, "R5 reset via frame number");
    for (int q = 0; q < NQ; q++) begin
      wr(14, 32'(q)); m_qsel = q;
      rd(8, 0, d);  check("R5 frame wiped", d, 32'h0);
      rd(22, 0, d); check("R5 vector released", d, 32'h0000_FFFF);
    end
    // R5 reset through status zero
    wr(4, 32'h77); wr(20, 32'd2); wr(8, 32'h55); wr(18, 32'h0F);
    wr(18, 32'h100); model_wipe();
    sweep(1'b1, "R5 reset via status");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule